// File: doc/BRIEF.md
# Multi-Mode Capture Timer

A 16-bit down-counter that software reaches through four byte-wide registers. It can count ticks from a selectable internal source, or edges seen on one external pin. It can also measure the time between pin edges by capturing the running count and restarting from a reload value. A two-bit mode field picks one of four behaviours: plain timer, period measurement, event counting, and continuous high/low pulse-width measurement. Two sticky flags, one for underflow and one for pin edges, drive the interrupt outputs.

The count source is the input clock divided by 16, the input clock divided by 2, or a single-cycle tick from an external oscillator. The source can also be switched off. The pin is synchronised before edge detection. A captured value stays frozen, and is what the count registers return, until software reads the high count byte.

The reset input is asserted asynchronously. Its release passes through a two-flop synchroniser, so the block starts updating on the third rising clock edge after `rst_n` goes high.

Top module: `capture_timer`

## Requirements
- R1: After reset every register reads 0x00, both interrupt outputs are low, and unused register bits always read 0.
- R2: The source field (address 1, bits 1:0) selects the count tick: 00 gives one tick every 16 clocks, 01 gives one every 2 clocks, 10 passes `osc_tick`, and 11 gives no tick.
- R3: On each tick the counter decrements by one. A tick at count zero reloads the counter from the reload latch and sets the underflow flag (address 1, bit 7).
- R4: While the stop bit (address 0, bit 7) is 1, the counter holds its value in every mode.
- R5: In event mode (address 0, bits 5:4 = 10), the counter ticks on synchronised pin rising edges when edge-select (address 0, bit 6) is 0, and on falling edges when it is 1. The source field has no effect in this mode.
- R6: In modes 00, 01 and 10, the edge flag (address 1, bit 6) sets on a falling pin edge when edge-select is 0, and on a rising pin edge when it is 1.
- R7: In period mode (01), the edge that sets the edge flag captures the current count and reloads the counter from the reload latch.
- R8: In pulse-width mode (11), both pin edges set the edge flag, capture the count and reload the counter, whatever edge-select holds.
- R9: While a capture is held, addresses 2 and 3 return the captured value, and later triggers do not overwrite it. The hold ends when software reads address 3 with `rd_en`.
- R10: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. A flag that is set and cleared in the same cycle ends up set.
- R11: A pin transition takes effect on the third rising clock edge after it appears at `pin_in`.
- R12: A write to address 2 stores the reload low byte. A write to address 3 stores the reload high byte and loads the counter with the high byte and the stored low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 3 releases a held capture |
| addr | input | 2 | Register address: 0 control, 1 source/flags, 2 count low byte, 3 count high byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| osc_tick | input | 1 | Single-cycle tick from the external oscillator |
| pin_in | input | 1 | External count/capture pin, asynchronous |
| irq_uf | output | 1 | Underflow flag |
| irq_edge | output | 1 | Pin-edge flag |

## Verification
The assertions check every cycle that a stopped counter holds its value, that an underflow reloads the counter and raises its flag, that the counter moves by at most one step when nothing else acts on it, and that a held capture keeps its value until the releasing read. Other behaviours appear only in the bench's scenarios, which compare against a behavioural model on every clock: the exact tick spacing of each source, the mapping of edge-select to rising or falling edges in each mode, the three-edge latency of the pin, and the capture-priority corners when a trigger meets a release.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_PULSE  = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_OSC  = 2'b10,
    SRC_OFF  = 2'b11
  } tmr_src_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam logic [1:0] ADDR_HI   = 2'd3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int DIV_SLOW = 16,
  parameter int DIV_FAST = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_src_e src_i,
  input  logic     osc_i,
  output logic     tick_o
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int FW = $clog2(DIV_FAST);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          slow_tick;
  logic          fast_tick;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign slow_tick = &pre_q;
  assign fast_tick = &pre_q[FW-1:0];

  always_comb begin
    unique case (src_i)
      SRC_SLOW: tick_o = slow_tick;
      SRC_FAST: tick_o = fast_tick;
      SRC_OSC:  tick_o = osc_i;
      default:  tick_o = 1'b0;
    endcase
  end

  AST_FAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_FAST && tick_o) |=> (src_i != SRC_FAST || !tick_o)); // R2
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             trig_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign uf_o = tick_i & ~stop_i & ~trig_i & (cnt_q == '0);

  always_comb begin
    cnt_en = load_i | (~stop_i & (trig_i | tick_i));
    if (load_i)                   cnt_d = load_val_i;
    else if (trig_i)              cnt_d = reload_i;
    else if (cnt_q == '0)         cnt_d = reload_i;
    else                          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> (cnt_q == $past(cnt_q))); // R4
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_o && !load_i) |=> (cnt_q == $past(reload_i))); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !trig_i && !uf_o) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_SLOW    = 16,
  parameter int DIV_FAST    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       osc_tick,
  input  logic       pin_in,
  output logic       irq_uf,
  output logic       irq_edge
);
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;

  // reset release synchroniser
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // register state
  logic             stop_q, esel_q;
  tmr_mode_e        mode_q;
  tmr_src_e         src_q;
  logic [CNT_W-1:0] reload_q;
  logic             uf_q, edge_q, hold_q;
  logic [CNT_W-1:0] cap_q;

  logic             uf_d, edge_d, hold_d;
  logic [CNT_W-1:0] cap_d;

  // strobes
  logic wr_ctrl, wr_src, wr_lo, wr_hi, rel;
  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_src  = wr_en && (addr == ADDR_SRC);
  assign wr_lo   = wr_en && (addr == ADDR_LO);
  assign wr_hi   = wr_en && (addr == ADDR_HI);
  assign rel     = rd_en && (addr == ADDR_HI);

  // pin edges and source tick
  logic rise, fall, src_tick;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_i  (src_q),
    .osc_i  (osc_tick),
    .tick_o (src_tick)
  );

  // mode decode
  logic sel_edge, ev_edge, trig, edge_set, core_tick, cap_take;

  always_comb begin
    sel_edge  = esel_q ? rise : fall;
    ev_edge   = esel_q ? fall : rise;
    trig      = ((mode_q == MODE_PERIOD) && sel_edge) ||
                ((mode_q == MODE_PULSE) && (rise || fall));
    edge_set  = (mode_q == MODE_PULSE) ? (rise || fall) : sel_edge;
    core_tick = (mode_q == MODE_EVENT) ? ev_edge : src_tick;
    cap_take  = trig && !hold_q;
  end

  logic [CNT_W-1:0] cnt;
  logic             uf;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (core_tick),
    .stop_i     (stop_q),
    .trig_i     (trig),
    .load_i     (wr_hi),
    .load_val_i ({wdata, reload_q[DATA_W-1:0]}),
    .reload_i   (reload_q),
    .cnt_o      (cnt),
    .uf_o       (uf)
  );

  // next state of flags and capture
  always_comb begin
    uf_d   = uf_q;
    edge_d = edge_q;
    if (wr_src && !wdata[7]) uf_d   = 1'b0;
    if (wr_src && !wdata[6]) edge_d = 1'b0;
    if (uf)                  uf_d   = 1'b1;
    if (edge_set)            edge_d = 1'b1;

    hold_d = hold_q;
    cap_d  = cap_q;
    if (cap_take) begin
      hold_d = 1'b1;
      cap_d  = cnt;
    end else if (rel) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stop_q   <= 1'b0;
      esel_q   <= 1'b0;
      mode_q   <= MODE_TIMER;
      src_q    <= SRC_SLOW;
      reload_q <= '0;
      uf_q     <= 1'b0;
      edge_q   <= 1'b0;
      hold_q   <= 1'b0;
      cap_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        stop_q <= wdata[7];
        esel_q <= wdata[6];
        mode_q <= tmr_mode_e'(wdata[5:4]);
      end
      if (wr_src) src_q <= tmr_src_e'(wdata[1:0]);
      if (wr_lo)  reload_q[DATA_W-1:0]     <= wdata;
      if (wr_hi)  reload_q[CNT_W-1:DATA_W] <= wdata;
      uf_q   <= uf_d;
      edge_q <= edge_d;
      hold_q <= hold_d;
      if (cap_take) cap_q <= cap_d;
    end
  end

  // read mux
  logic [CNT_W-1:0] view;
  assign view = hold_q ? cap_q : cnt;

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = {stop_q, esel_q, mode_q, 4'b0000};
      ADDR_SRC:  rdata = {uf_q, edge_q, 4'b0000, src_q};
      ADDR_LO:   rdata = view[DATA_W-1:0];
      default:   rdata = view[CNT_W-1:DATA_W];
    endcase
  end

  assign irq_uf   = uf_q;
  assign irq_edge = edge_q;

  AST_UF_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    uf |=> uf_q); // R3
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode_q == MODE_PULSE) && (rise || fall)) |=> edge_q); // R8
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hold_q && !rel) |=> (hold_q && cap_q == $past(cap_q))); // R9
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trig && !hold_q) |=> (cap_q == $past(cnt))); // R7
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_q == SRC_OFF && mode_q != MODE_EVENT) |-> !core_tick); // R2
endmodule

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       osc_tick, pin_in;
  logic       irq_uf, irq_edge;

  always #2.5 clk = ~clk;

  capture_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .osc_tick(osc_tick), .pin_in(pin_in),
    .irq_uf(irq_uf), .irq_edge(irq_edge)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string phase    = "R1";

  // behavioural reference
  int          m_since;
  bit          m_s1, m_s2, m_s3;
  int          m_pre;
  bit [15:0]   m_cnt, m_rel, m_cap;
  bit          m_hold, m_stop, m_esel, m_ufl, m_edf;
  int          m_mode, m_src;

  task automatic m_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
    m_cnt = 0; m_rel = 0; m_cap = 0; m_hold = 0;
    m_stop = 0; m_esel = 0; m_ufl = 0; m_edf = 0;
    m_mode = 0; m_src = 0;
  endtask

  task automatic m_step();
    bit rise, fall, sel, ev, trig, fset, stick, tick, uf;
    rise = m_s2 && !m_s3;
    fall = !m_s2 && m_s3;
    sel  = m_esel ? rise : fall;
    ev   = m_esel ? fall : rise;
    trig = (m_mode == 1 && sel) || (m_mode == 3 && (rise || fall));
    fset = (m_mode == 3) ? (rise || fall) : sel;
    case (m_src)
      0: stick = (m_pre % 16) == 15;
      1: stick = (m_pre % 2) == 1;
      2: stick = osc_tick;
      default: stick = 0;
    endcase
    tick = (m_mode == 2) ? ev : stick;
    uf   = tick && !m_stop && !trig && m_cnt == 0;
    // capture before counter moves
    if (trig && !m_hold) begin m_cap = m_cnt; m_hold = 1; end
    else if (rd_en && addr == 3) m_hold = 0;
    // counter
    if (wr_en && addr == 3) m_cnt = {wdata, m_rel[7:0]};
    else if (!m_stop) begin
      if (trig) m_cnt = m_rel;
      else if (tick) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 16'd1;
    end
    // flags
    if (uf) m_ufl = 1; else if (wr_en && addr == 1 && !wdata[7]) m_ufl = 0;
    if (fset) m_edf = 1; else if (wr_en && addr == 1 && !wdata[6]) m_edf = 0;
    // register writes
    if (wr_en) begin
      case (addr)
        0: begin m_stop = wdata[7]; m_esel = wdata[6]; m_mode = wdata[5:4]; end
        1: m_src = wdata[1:0];
        2: m_rel[7:0] = wdata;
        default: m_rel[15:8] = wdata;
      endcase
    end
    m_pre = (m_pre + 1) % 16;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
  endtask

  function automatic bit [7:0] m_read(input logic [1:0] a);
    bit [15:0] v;
    v = m_hold ? m_cap : m_cnt;
    case (a)
      2'd0: return {m_stop, m_esel, 2'(m_mode), 4'b0};
      2'd1: return {m_ufl, m_edf, 4'b0, 2'(m_src)};
      2'd2: return v[7:0];
      default: return v[15:8];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_reset(); m_since = 0; end
    else if (m_since < 2) m_since++;
    else m_step();
  end

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    chk(phase, $sformatf("rdata@%0d", addr), rdata, m_read(addr));
    chk(phase, "irq_uf", {7'b0, irq_uf}, {7'b0, m_ufl});
    chk(phase, "irq_edge", {7'b0, irq_edge}, {7'b0, m_edf});
  end

  // background stimulus
  int       pin_half = 0;
  int       pin_cnt  = 0;
  bit       osc_en   = 0;
  bit [7:0] lfsr     = 8'h5a;
  int       rot      = 0;

  task automatic bg();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    osc_tick = osc_en && lfsr[0];
    if (pin_half > 0) begin
      pin_cnt++;
      if (pin_cnt >= pin_half) begin pin_cnt = 0; pin_in = ~pin_in; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      wr_en = 0; rd_en = 0; addr = 2'(rot); rot++;
      bg();
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    bg();
  endtask

  task automatic rd_release();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 1; addr = 2'd3;
    bg();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    osc_tick = 0; pin_in = 0;
    // R1: reset values, unused bits zero
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #1; addr = 2'(a);
      @(negedge clk); chk("R1", "reset read", rdata, 8'h00);
    end
    @(negedge clk);
    chk("R1", "irq_uf reset", {7'b0, irq_uf}, 8'h00);
    chk("R1", "irq_edge reset", {7'b0, irq_edge}, 8'h00);
    @(posedge clk); #1; rst_n = 1;
    idle(4);

    phase = "R12"; wr(2, 8'h05); wr(3, 8'h00); idle(3);
    phase = "R3";  wr(1, 8'h01); idle(60);
    phase = "R4";  wr(0, 8'h80); idle(20);
    phase = "R10"; wr(1, 8'h01); idle(6); wr(1, 8'hC1); idle(5); wr(0, 8'h00);
    idle(20); wr(1, 8'h01); idle(10);
    phase = "R2";  wr(1, 8'h00); idle(80);
    osc_en = 1; wr(1, 8'h02); idle(60); osc_en = 0;
    wr(1, 8'h03); idle(40); wr(1, 8'h01);
    phase = "R5";  wr(2, 8'h03); wr(3, 8'h00); pin_half = 3;
    wr(0, 8'h20); idle(80); wr(0, 8'h60); idle(80);
    wr(1, 8'h03); idle(40); wr(1, 8'h01);
    phase = "R6";  wr(0, 8'h00); wr(1, 8'h01); idle(60);
    wr(0, 8'h40); wr(1, 8'h01); idle(60);
    phase = "R7";  wr(2, 8'h00); wr(3, 8'h01); pin_half = 11;
    wr(0, 8'h10); wr(1, 8'h01); idle(100); rd_release(); idle(50); rd_release();
    wr(0, 8'h50); idle(80); rd_release(); idle(40);
    phase = "R8";  wr(0, 8'h30); wr(1, 8'h01); idle(60); rd_release(); idle(30);
    wr(0, 8'h70); idle(60); rd_release(); idle(20);
    phase = "R9";  wr(0, 8'h30); idle(70); rd_release(); idle(15); rd_release(); idle(40);
    wr(0, 8'hB0); idle(40); rd_release(); idle(20); wr(0, 8'h30);
    phase = "R11"; pin_half = 1; idle(30); pin_half = 2; wr(0, 8'h10); idle(30);
    rd_release(); idle(20); pin_half = 0; idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule